// File: doc/BRIEF.md
# Shadow-to-Persistent Register Copy Controller

This block connects a bank of 32-bit shadow registers, written by the CPU, to slow storage in an always-powered domain. The bank holds eight words. Index 0 is the milliseconds word and index 1 is the alarm word. Indices 2 to 7 are general persistent words 0 to 5. General word 0 (index 2) is kept for hardware configuration, and general words 1 to 5 are free for software.

A write to a shadow word stores the value and raises that word's bit in a read-only pending vector. One serial copy engine moves pending words to the persistent side, one whole word per transfer. It uses a request/acknowledge handshake that carries a 4-bit index and 32 bits of data. When several words are pending, the engine serves the lowest index first. A word's pending bit falls only once its transfer has been acknowledged.

Software may write any word whose own pending bit is clear, even while another word is being copied. A suppress input stops new transfers from starting. A synchronous soft reset clears the shadow words and the pending vector, and it aborts the transfer in flight.

Top module: `shadow_copy_ctrl`

## Requirements
- R1: After reset every shadow word reads 0. A write to index i (0 to 7) is returned on `rd_data` for `rd_idx` = i from the next cycle on.
- R2: A write to index i sets `pend_o[i]` from the next cycle. The bit falls in the cycle after the transfer of word i is acknowledged, and not earlier.
- R3: Only one transfer runs at a time. While `pers_req` is high and `pers_ack` is low, `pers_req`, `pers_idx` and `pers_data` hold their values.
- R4: When a new request starts, `pers_idx` is the lowest index whose pending bit was set in the cycle before.
- R5: A write to a non-pending word during a transfer is accepted. That word is copied after the current transfer ends.
- R6: While the engine is idle and `suppress_copy` is high, no request starts. A transfer already running completes regardless of `suppress_copy`.
- R7: `soft_rst` clears all shadow words and the whole pending vector, and it drops `pers_req`, all in the next cycle.
- R8: Each transferred word carries the shadow value that was current when its request began. After the queue drains, the persistent side holds the last legally written value of every word, for any write order and any responder latency.
- R9: A write with `wr_idx` of 8 or more changes no shadow word and no pending bit, and it starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset; aborts queued copies |
| suppress_copy | input | 1 | Blocks new transfers from starting while high |
| wr_en | input | 1 | Shadow write strobe |
| wr_idx | input | 4 | Shadow word index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Shadow word index for read-back |
| rd_data | output | 32 | Read-back value (0 for an index out of range) |
| pend_o | output | 8 | One pending bit per shadow word |
| pers_req | output | 1 | Transfer request to the persistent side |
| pers_idx | output | 4 | Index of the word being transferred |
| pers_data | output | 32 | Word being transferred |
| pers_ack | input | 1 | Responder acknowledge, one cycle, while the request is high |

## Verification
The copy path is first swept over every word at every fixed responder latency from 0 to 5. This separates errors in addressing and timing from errors in ordering. Bursts that write all words in descending order, and writes that land while a transfer is in flight, exercise lowest-index-first selection and acceptance during a busy engine. A long run then uses random legal write orders and a random latency for each transfer, and compares the final persistent contents with the last value written to each word. Directed cases cover suppress while idle and while busy, soft reset during a transfer, and writes to unused indices, to show what each of these blocks or leaves untouched.

// File: rtl/scc_pkg.sv
package scc_pkg;
   // fixed placement of the bank words; priority follows these indices
   localparam int unsigned SCC_REG_MS    = 0;
   localparam int unsigned SCC_REG_ALARM = 1;
   localparam int unsigned SCC_REG_GP0   = 2;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_BUSY = 1'b1
   } eng_state_e;
endpackage

// File: rtl/scc_shadow_bank.sv
module scc_shadow_bank #(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IDX_W-1:0]  cp_idx,
   output logic [DATA_W-1:0] cp_data
);
   logic [DATA_W-1:0] word_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        word_q[g] <= '0;
         else if (soft_rst) word_q[g] <= '0;
         else if (hit)      word_q[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      cp_data = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_idx == IDX_W'(k)) rd_data = word_q[k];
         if (cp_idx == IDX_W'(k)) cp_data = word_q[k];
      end
   end
endmodule

// File: rtl/scc_pending_tracker.sv
module scc_pending_tracker #(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic                done,
   input  logic [IDX_W-1:0]    done_idx,
   output logic [NUM_REGS-1:0] pend
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
      logic set_i, clr_i;
      assign set_i = wr_en && (wr_idx == IDX_W'(g));
      assign clr_i = done && (done_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend[g] <= 1'b0;
         else if (soft_rst) pend[g] <= 1'b0;
         else if (set_i)    pend[g] <= 1'b1;   // a fresh write outranks a finishing copy
         else if (clr_i)    pend[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/scc_copy_engine.sv
module scc_copy_engine
   import scc_pkg::*;
#(
   parameter int unsigned NUM_REGS     = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned IDX_W        = 4,
   parameter bit          CAPTURE_WORD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                suppress,
   input  logic [NUM_REGS-1:0] pend,
   input  logic [DATA_W-1:0]   cp_data,
   output logic [IDX_W-1:0]    cp_idx,
   output logic                req,
   output logic [IDX_W-1:0]    idx,
   output logic [DATA_W-1:0]   data,
   input  logic                ack,
   output logic                done
);
   eng_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  pick;
   logic              any_pend;
   logic              start;

   always_comb begin
      pick = '0;
      for (int k = NUM_REGS - 1; k >= 0; k--) begin
         if (pend[k]) pick = IDX_W'(k);
      end
   end

   assign any_pend = |pend;
   assign start    = (state_q == ENG_IDLE) && any_pend && !suppress && !soft_rst;
   assign cp_idx   = (state_q == ENG_IDLE) ? pick : idx_q;
   assign req      = (state_q == ENG_BUSY);
   assign idx      = idx_q;
   assign done     = req && ack && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         idx_q   <= '0;
      end else if (soft_rst) begin
         state_q <= ENG_IDLE;
      end else begin
         case (state_q)
            ENG_IDLE: if (start) begin
               state_q <= ENG_BUSY;
               idx_q   <= pick;
            end
            ENG_BUSY: if (ack) state_q <= ENG_IDLE;
            default:  state_q <= ENG_IDLE;
         endcase
      end
   end

   if (CAPTURE_WORD) begin : g_capture
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     data_q <= '0;
         else if (start) data_q <= cp_data;
      end
      assign data = data_q;
   end else begin : g_direct
      assign data = cp_data;
   end
endmodule

// File: rtl/shadow_copy_ctrl.sv
module shadow_copy_ctrl #(
   parameter int unsigned NUM_REGS     = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned IDX_W        = 4,
   parameter bit          CAPTURE_WORD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                suppress_copy,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_REGS-1:0] pend_o,
   output logic                pers_req,
   output logic [IDX_W-1:0]    pers_idx,
   output logic [DATA_W-1:0]   pers_data,
   input  logic                pers_ack
);
   localparam int unsigned IDX_SPAN = 1 << IDX_W;

   if (NUM_REGS < 1 || NUM_REGS > IDX_SPAN) begin : g_bad_count
      $error("shadow_copy_ctrl: NUM_REGS must fit the index width");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("shadow_copy_ctrl: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  cp_idx;
   logic [DATA_W-1:0] cp_data;
   logic              done;

   scc_shadow_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) bank_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .cp_idx(cp_idx), .cp_data(cp_data)
   );

   scc_pending_tracker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) track_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_idx(wr_idx),
      .done(done), .done_idx(pers_idx),
      .pend(pend_o)
   );

   scc_copy_engine #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .CAPTURE_WORD(CAPTURE_WORD)
   ) eng_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .suppress(suppress_copy),
      .pend(pend_o), .cp_data(cp_data), .cp_idx(cp_idx),
      .req(pers_req), .idx(pers_idx), .data(pers_data),
      .ack(pers_ack), .done(done)
   );
endmodule

// File: rtl/scc_chk.sv
module scc_chk #(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                soft_rst,
   input logic                suppress_copy,
   input logic                wr_en,
   input logic [IDX_W-1:0]    wr_idx,
   input logic [NUM_REGS-1:0] pend_o,
   input logic                pers_req,
   input logic [IDX_W-1:0]    pers_idx,
   input logic [DATA_W-1:0]   pers_data,
   input logic                pers_ack
);
   localparam logic [IDX_W:0] NREG_X = (IDX_W+1)'(NUM_REGS);

   function automatic logic [IDX_W-1:0] low_of(input logic [NUM_REGS-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int k = NUM_REGS - 1; k >= 0; k--) if (v[k]) r = IDX_W'(k);
      return r;
   endfunction

   // R2
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_idx} < NREG_X) && !soft_rst) |=> pend_o[$past(wr_idx)]);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pers_req && !pers_ack && !soft_rst) |=>
         (pers_req && $stable(pers_idx) && $stable(pers_data)));

   // R4
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pers_req) |-> (pers_idx == low_of($past(pend_o))));

   // R6
   suppress_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pers_req && suppress_copy) |=> !pers_req);

   // R7
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (pend_o == '0) && !pers_req);

   // R9
   bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_idx} >= NREG_X) && !pers_req && !pers_ack && !soft_rst)
         |=> (pend_o == $past(pend_o)));
endmodule

bind shadow_copy_ctrl scc_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .suppress_copy(suppress_copy),
   .wr_en(wr_en), .wr_idx(wr_idx), .pend_o(pend_o),
   .pers_req(pers_req), .pers_idx(pers_idx), .pers_data(pers_data), .pers_ack(pers_ack)
);

// File: tb/shadow_copy_ctrl_tb_top.sv
`timescale 1ns/1ps
module shadow_copy_ctrl_tb_top;
   localparam int NR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, soft_rst = 1'b0, suppress_copy = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0, rd_idx = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data, pers_data;
   logic [7:0]  pend_o;
   logic        pers_req;
   logic [3:0]  pers_idx;
   logic        pers_ack = 1'b0;

   always #2 clk = ~clk;

   shadow_copy_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .suppress_copy(suppress_copy),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .pend_o(pend_o),
      .pers_req(pers_req), .pers_idx(pers_idx), .pers_data(pers_data),
      .pers_ack(pers_ack)
   );

   int n_chk = 0, n_bad = 0;
   logic [31:0] sh_m [NR];
   logic [31:0] pm   [NR];
   logic [7:0]  pend_m = '0, snap = '0;
   int          lat = 0, cnt = 0;
   bit          lat_rand = 1'b0, req_prev = 1'b0;
   logic [3:0]  r_idx = '0;
   logic [31:0] r_data = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] lowest(input logic [7:0] v);
      logic [3:0] r = '0;
      for (int k = NR - 1; k >= 0; k--) if (v[k]) r = 4'(k);
      return r;
   endfunction

   // one cycle: responder, monitors, then the caller may drive new inputs
   task automatic tick();
      @(negedge clk);
      wr_en = 1'b0;
      soft_rst = 1'b0;
      if (pers_ack) begin
         pers_ack = 1'b0;
         pm[r_idx] = r_data;
         chk(r_data == sh_m[r_idx], "R8 copied word", r_data, sh_m[r_idx]);
         pend_m[r_idx] = 1'b0;
         cnt = 0;
      end else if (pers_req) begin
         if (!req_prev) begin
            r_idx = pers_idx;
            r_data = pers_data;
            cnt = 0;
            chk(pers_idx == lowest(snap), "R4 start index", 32'(pers_idx), 32'(lowest(snap)));
            if (lat_rand) lat = $urandom_range(0, 6);
         end else begin
            chk(pers_idx == r_idx && pers_data == r_data, "R3 request held", pers_data, r_data);
         end
         if (cnt >= lat) pers_ack = 1'b1;
         else cnt++;
      end else begin
         cnt = 0;
      end
      req_prev = pers_req;
      chk(pend_o == pend_m, "R2 pending vector", 32'(pend_o), 32'(pend_m));
      snap = pend_m;
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d);
      wr_en = 1'b1;
      wr_idx = i;
      wr_data = d;
      if (i < NR) begin
         sh_m[i] = d;
         pend_m[i] = 1'b1;
      end
   endtask

   task automatic rdchk(input logic [3:0] i, input logic [31:0] exp, input string tag);
      rd_idx = i;
      #1;
      chk(rd_data == exp, tag, rd_data, exp);
   endtask

   task automatic drain();
      for (int k = 0; k < 400; k++) begin
         if (pend_m == '0 && !pers_req && !pers_ack) break;
         tick();
      end
      tick();
   endtask

   initial begin
      for (int k = 0; k < NR; k++) begin sh_m[k] = '0; pm[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(pers_req == 1'b0, "R1 reset request", 32'(pers_req), 0);
      for (int k = 0; k < NR; k++) rdchk(4'(k), 32'h0, "R1 reset word");

      // sweep every word at every fixed latency
      for (int l = 0; l < 6; l++) begin
         lat = l;
         for (int k = 0; k < NR; k++) begin
            logic [31:0] v = 32'hA000_0000 + 32'(l * 256 + k * 17);
            wr(4'(k), v);
            tick();
            rdchk(4'(k), v, "R1 read-back");
            drain();
            chk(pm[k] == v, "R8 sweep persistent", pm[k], v);
         end
      end

      // R9 out-of-range writes
      wr(4'd9, 32'hDEAD_0009);
      tick();
      wr(4'd15, 32'hDEAD_000F);
      tick();
      tick();
      chk(pers_req == 1'b0, "R9 no request", 32'(pers_req), 0);
      rdchk(4'd9, 32'h0, "R9 unused read");
      for (int k = 0; k < NR; k++) rdchk(4'(k), sh_m[k], "R9 words untouched");

      // R5 writes accepted while busy
      lat = 4;
      wr(4'd5, 32'h5555_0005);
      tick();
      while (!pers_req) tick();
      wr(4'd7, 32'h7777_0007);
      tick();
      wr(4'd2, 32'h2222_0002);
      tick();
      drain();
      chk(pm[7] == 32'h7777_0007, "R5 later copy", pm[7], 32'h7777_0007);
      chk(pm[2] == 32'h2222_0002, "R5 later copy", pm[2], 32'h2222_0002);

      // descending burst; R4 monitored per request
      lat = 1;
      for (int k = NR - 1; k >= 0; k--) begin
         wr(4'(k), 32'hB000_0000 + 32'(k));
         tick();
      end
      drain();
      for (int k = 0; k < NR; k++) chk(pm[k] == 32'hB000_0000 + 32'(k), "R4 burst result", pm[k], 32'hB000_0000 + 32'(k));

      // R6 suppress while idle
      suppress_copy = 1'b1;
      wr(4'd3, 32'h3333_0003);
      tick();
      wr(4'd6, 32'h6666_0006);
      for (int k = 0; k < 10; k++) begin
         tick();
         chk(pers_req == 1'b0, "R6 suppressed idle", 32'(pers_req), 0);
      end
      suppress_copy = 1'b0;
      drain();
      chk(pm[3] == 32'h3333_0003, "R6 released copy", pm[3], 32'h3333_0003);
      // R6 suppress raised while busy
      lat = 6;
      wr(4'd4, 32'h4444_0004);
      tick();
      while (!pers_req) tick();
      suppress_copy = 1'b1;
      wr(4'd1, 32'h1111_0001);
      while (pend_m[4]) tick();
      chk(pm[4] == 32'h4444_0004, "R6 busy completes", pm[4], 32'h4444_0004);
      for (int k = 0; k < 8; k++) begin
         tick();
         chk(pers_req == 1'b0, "R6 no start after", 32'(pers_req), 0);
      end
      suppress_copy = 1'b0;
      drain();
      chk(pm[1] == 32'h1111_0001, "R6 released copy", pm[1], 32'h1111_0001);

      // R7 soft reset during a transfer
      lat = 5;
      wr(4'd0, 32'hC0C0_0000);
      tick();
      wr(4'd6, 32'hC0C0_0006);
      tick();
      while (!pers_req) tick();
      soft_rst = 1'b1;
      for (int k = 0; k < NR; k++) begin sh_m[k] = '0; end
      pend_m = '0;
      tick();
      chk(pers_req == 1'b0, "R7 request dropped", 32'(pers_req), 0);
      chk(pend_o == 8'h00, "R7 pending cleared", 32'(pend_o), 0);
      for (int k = 0; k < NR; k++) rdchk(4'(k), 32'h0, "R7 word cleared");
      repeat (4) tick();

      // random legal orders with random latency
      begin
         logic [7:0] seen = '0;
         lat_rand = 1'b1;
         for (int t = 0; t < 3000; t++) begin
            tick();
            if ($urandom_range(0, 9) < 3) begin
               int i = $urandom_range(0, NR - 1);
               if (!pend_m[i]) begin
                  wr(4'(i), $urandom);
                  seen[i] = 1'b1;
               end
            end
         end
         drain();
         for (int k = 0; k < NR; k++)
            if (seen[k]) chk(pm[k] == sh_m[k], "R8 final persistent", pm[k], sh_m[k]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule